// File: doc/BRIEF.md
# Frame Statistics Counter Bank

This block keeps per-direction traffic statistics for an Ethernet MAC. Every time the receive or transmit path finishes a frame it presents one completion event: a valid strobe, the frame length in bytes and a small flag vector. The block adds the length to a byte total, counts the frame in a frame total, counts it in each flag counter whose flag is set, and puts it in one bin of a seven-bin size histogram. Receive and transmit keep fully separate counter sets, so both directions can report an event in the same cycle.

Software reads the counters through a single-cycle register read port. Every counter clears as it is read, so software only has to add each value into its own wider total. The two wide totals (bytes and frames) do not fit in 32 bits. Reading the low word returns bits 31:0 and, in the same cycle, copies the upper bits into a shadow register. A later read of the high word returns that shadow, which keeps the two halves consistent. A global clear input resets every counter and shadow at once. Counters saturate at all ones and never wrap.

Top module: `rmon_stats`

## Requirements
- R1: After reset, every counter and every shadow reads as zero.
- R2: The byte total of a direction (width WIDE_W, default 45) adds the length of each event. A read at index 0 returns bits 31:0. The same read copies bits WIDE_W-1:32 into a shadow register, and a read at index 1 returns that shadow in its low bits. The shadow holds until the next index-0 read or a global clear.
- R3: The frame total of a direction (width WIDE_W) counts one for each event. It is read at index 2 (low word) and index 3 (shadowed high word), with the same latching rule as R2.
- R4: The receive flag bits map as follows: bit0 multicast, bit1 broadcast, bit2 pause, bit3 FCS error, bit4 short, bit5 oversize, bit6 jabber, bit7 symbol-code error. Each set bit counts the event in the 32-bit counter at receive index 4+bit.
- R5: The transmit flag bits map as follows: bit0 multicast, bit1 broadcast, bit2 pause, bit3 any error (bad FCS or underrun). Each set bit counts the event in the counter at transmit index 4+bit.
- R6: Each event with length of at least 64 counts in exactly one histogram bin. Bin k covers 64, 65-127, 128-255, 256-511, 512-1023, 1024-1518 or 1519 and above, for k = 0 to 6. Bin k sits at receive index 12+k and at transmit index 8+k.
- R7: An event shorter than 64 bytes counts in no histogram bin.
- R8: A read returns the counter value from before that cycle, and clears the counter. An event in the same cycle as the clearing read leaves the counter at that event's increment.
- R9: Every counter saturates at its all-ones value and does not wrap.
- R10: A high clr_stats input clears every counter and both shadows of both directions in one cycle.
- R11: Address bit ADDR_W-1 selects the direction (0 receive, 1 transmit). Events of one direction never change the counters of the other direction.
- R12: rd_data is registered. It takes the addressed value on the clock edge where rd_en is high and holds its value otherwise. Unmapped indices read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_stats | input | 1 | Clears all counters and shadows |
| rx_valid | input | 1 | Receive frame completion event |
| rx_len | input | LEN_W | Receive frame length in bytes |
| rx_flags | input | 8 | Receive frame flags (see R4) |
| tx_valid | input | 1 | Transmit frame completion event |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| tx_flags | input | 4 | Transmit frame flags (see R5) |
| rd_en | input | 1 | Read strobe; clears the addressed counter |
| rd_addr | input | ADDR_W | Direction bit and counter index |
| rd_data | output | 32 | Registered read data |

## Verification
The bench drives single frames with chosen lengths and flag patterns. Each one isolates a single counter, so a wrong flag-to-counter mapping or a misplaced address shows up directly. A sweep of lengths sits on both sides of every histogram edge, including 63, to catch off-by-one bin limits. A long back-to-back burst of maximum-length transmit frames pushes the byte total past 32 bits and a narrowed histogram bin past its saturation point, which tests the shadowed high word and the no-wrap rule. An event placed in the same cycle as a clearing read separates a correct clear-then-count from a lost or doubled increment, and traffic on one direction checks that the other direction's counters stay untouched.

// File: rtl/rmon_pkg.sv
package rmon_pkg;
   localparam int NUM_BINS   = 7;
   localparam int RX_FLAG_W  = 8;
   localparam int TX_FLAG_W  = 4;
   localparam int IDX_OCT_LO = 0;
   localparam int IDX_OCT_HI = 1;
   localparam int IDX_FRM_LO = 2;
   localparam int IDX_FRM_HI = 3;
   localparam int IDX_EV0    = 4;

   // lower and upper bound of histogram bin k (inclusive)
   function automatic logic [31:0] bin_lo(input int k);
      if (k == 0)      return 32'd64;
      else if (k == 1) return 32'd65;
      else if (k == 6) return 32'd1519;
      else             return 32'd64 << (k - 1);
   endfunction

   function automatic logic [31:0] bin_hi(input int k);
      if (k == 0)      return 32'd64;
      else if (k == 5) return 32'd1518;
      else if (k == 6) return 32'hFFFF_FFFF;
      else             return (32'd128 << (k - 1)) - 32'd1;
   endfunction
endpackage

// File: rtl/rmon_sat_ctr.sv
module rmon_sat_ctr #(
   parameter int W     = 32,
   parameter int INC_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [INC_W-1:0] inc_val,
   output logic [W-1:0]     q
);
   logic [W-1:0] base;
   logic [W:0]   sum;
   logic [W-1:0] nxt;

   initial assert (W > INC_W) else $error("rmon_sat_ctr: W must exceed INC_W");

   always_comb begin
      base = clr ? '0 : q;
      sum  = {1'b0, base} + {{(W + 1 - INC_W){1'b0}}, inc_val};
      nxt  = sum[W] ? '1 : sum[W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (q == '1) && !clr |=> q == '1);
   p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> q >= $past(q));
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> q == W'($past(inc_val)));
endmodule

// File: rtl/rmon_len_bins.sv
module rmon_len_bins
   import rmon_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic [LEN_W-1:0]    len,
   output logic [NUM_BINS-1:0] bin_hit
);
   logic [31:0] len_ext;

   initial assert (LEN_W >= 11 && LEN_W <= 32) else $error("rmon_len_bins: LEN_W out of range");

   assign len_ext = 32'(len);

   for (genvar k = 0; k < NUM_BINS; k++) begin : g_bin
      assign bin_hit[k] = (len_ext >= bin_lo(k)) && (len_ext <= bin_hi(k));
   end

   always_comb begin
      p_bin_onehot_r6: assert ($onehot0(bin_hit));
      if (len_ext < 32'd64) p_short_nobin_r7: assert (bin_hit == '0);
   end
endmodule

// File: rtl/rmon_dir_bank.sv
module rmon_dir_bank
   import rmon_pkg::*;
#(
   parameter int N_EV   = 15,
   parameter int LEN_W  = 16,
   parameter int WIDE_W = 45,
   parameter int CNT_W  = 32,
   parameter int IDX_W  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_all,
   input  logic             ev_valid,
   input  logic [LEN_W-1:0] ev_len,
   input  logic [N_EV-1:0]  ev_hit,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [31:0]      rd_word
);
   localparam int SH_W = WIDE_W - 32;

   initial assert (WIDE_W > 32 && WIDE_W <= 64 && CNT_W <= 32 && IDX_EV0 + N_EV <= (1 << IDX_W))
      else $error("rmon_dir_bank: bad parameters");

   logic              rd_oct, rd_frm;
   logic [WIDE_W-1:0] oct_q, frm_q;
   logic [SH_W-1:0]   oct_sh, frm_sh;
   logic [LEN_W-1:0]  oct_inc;
   logic [CNT_W-1:0]  ev_q [N_EV];

   assign rd_oct  = rd_en && (rd_idx == IDX_W'(IDX_OCT_LO));
   assign rd_frm  = rd_en && (rd_idx == IDX_W'(IDX_FRM_LO));
   assign oct_inc = ev_valid ? ev_len : '0;

   rmon_sat_ctr #(.W(WIDE_W), .INC_W(LEN_W)) u_oct (
      .clk(clk), .rst_n(rst_n), .clr(clr_all | rd_oct), .inc_val(oct_inc), .q(oct_q));

   rmon_sat_ctr #(.W(WIDE_W), .INC_W(1)) u_frm (
      .clk(clk), .rst_n(rst_n), .clr(clr_all | rd_frm), .inc_val(ev_valid), .q(frm_q));

   for (genvar i = 0; i < N_EV; i++) begin : g_ev
      logic rd_me;
      assign rd_me = rd_en && (rd_idx == IDX_W'(IDX_EV0 + i));
      rmon_sat_ctr #(.W(CNT_W), .INC_W(1)) u_ctr (
         .clk(clk), .rst_n(rst_n), .clr(clr_all | rd_me),
         .inc_val(ev_valid & ev_hit[i]), .q(ev_q[i]));
   end

   // shadows of the upper bits, captured by the low-word read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oct_sh <= '0;
         frm_sh <= '0;
      end else if (clr_all) begin
         oct_sh <= '0;
         frm_sh <= '0;
      end else begin
         if (rd_oct) oct_sh <= oct_q[WIDE_W-1:32];
         if (rd_frm) frm_sh <= frm_q[WIDE_W-1:32];
      end
   end

   always_comb begin
      rd_word = '0;
      if (rd_idx == IDX_W'(IDX_OCT_LO))      rd_word = oct_q[31:0];
      else if (rd_idx == IDX_W'(IDX_OCT_HI)) rd_word = 32'(oct_sh);
      else if (rd_idx == IDX_W'(IDX_FRM_LO)) rd_word = frm_q[31:0];
      else if (rd_idx == IDX_W'(IDX_FRM_HI)) rd_word = 32'(frm_sh);
      else begin
         for (int k = 0; k < N_EV; k++)
            if (rd_idx == IDX_W'(IDX_EV0 + k)) rd_word = 32'(ev_q[k]);
      end
   end

   p_shadow_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_oct && !clr_all |=> $stable(oct_sh));
   p_shadow_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_frm && !clr_all |=> frm_sh == $past(frm_q[WIDE_W-1:32]));
endmodule

// File: rtl/rmon_stats.sv
module rmon_stats
   import rmon_pkg::*;
#(
   parameter int LEN_W  = 16,
   parameter int CNT_W  = 32,
   parameter int WIDE_W = 45,
   parameter int ADDR_W = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_stats,
   input  logic                 rx_valid,
   input  logic [LEN_W-1:0]     rx_len,
   input  logic [RX_FLAG_W-1:0] rx_flags,
   input  logic                 tx_valid,
   input  logic [LEN_W-1:0]     tx_len,
   input  logic [TX_FLAG_W-1:0] tx_flags,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [31:0]          rd_data
);
   localparam int IDX_W   = ADDR_W - 1;
   localparam int RX_N_EV = RX_FLAG_W + NUM_BINS;
   localparam int TX_N_EV = TX_FLAG_W + NUM_BINS;

   initial assert (ADDR_W >= 6) else $error("rmon_stats: ADDR_W too small");

   logic                rd_tx;
   logic [IDX_W-1:0]    rd_idx;
   logic [NUM_BINS-1:0] rx_bins, tx_bins;
   logic [31:0]         rx_word, tx_word;

   assign rd_tx  = rd_addr[ADDR_W-1];
   assign rd_idx = rd_addr[IDX_W-1:0];

   rmon_len_bins #(.LEN_W(LEN_W)) u_rx_bins (.len(rx_len), .bin_hit(rx_bins));
   rmon_len_bins #(.LEN_W(LEN_W)) u_tx_bins (.len(tx_len), .bin_hit(tx_bins));

   rmon_dir_bank #(.N_EV(RX_N_EV), .LEN_W(LEN_W), .WIDE_W(WIDE_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr_all(clr_stats),
      .ev_valid(rx_valid), .ev_len(rx_len), .ev_hit({rx_bins, rx_flags}),
      .rd_en(rd_en && !rd_tx), .rd_idx(rd_idx), .rd_word(rx_word));

   rmon_dir_bank #(.N_EV(TX_N_EV), .LEN_W(LEN_W), .WIDE_W(WIDE_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .clr_all(clr_stats),
      .ev_valid(tx_valid), .ev_len(tx_len), .ev_hit({tx_bins, tx_flags}),
      .rd_en(rd_en && rd_tx), .rd_idx(rd_idx), .rd_word(tx_word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_tx ? tx_word : rx_word;
   end

   p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
endmodule

// File: tb/rmon_stats_tb.sv
module rmon_stats_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LEN_W = 16;
   localparam int CNT_W = 6;     // narrowed so saturation is reachable
   localparam int TX = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr_stats = 1'b0;
   logic        rx_valid = 1'b0, tx_valid = 1'b0;
   logic [15:0] rx_len = '0, tx_len = '0;
   logic [7:0]  rx_flags = '0;
   logic [3:0]  tx_flags = '0;
   logic        rd_en = 1'b0;
   logic [6:0]  rd_addr = '0;
   logic [31:0] rd_data;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rmon_stats #(.LEN_W(LEN_W), .CNT_W(CNT_W), .WIDE_W(45), .ADDR_W(7)) u_dut (
      .clk(clk), .rst_n(rst_n), .clr_stats(clr_stats),
      .rx_valid(rx_valid), .rx_len(rx_len), .rx_flags(rx_flags),
      .tx_valid(tx_valid), .tx_len(tx_len), .tx_flags(tx_flags),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic rd(input int addr, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; rd_addr = 7'(addr);
      @(negedge clk); rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic rd_chk(input string req, input int addr, input logic [31:0] exp);
      logic [31:0] d;
      rd(addr, d);
      check(req, d, exp);
   endtask

   task automatic rx_ev(input int len, input logic [7:0] fl);
      @(negedge clk); rx_valid = 1'b1; rx_len = 16'(len); rx_flags = fl;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic tx_ev(input int len, input logic [3:0] fl);
      @(negedge clk); tx_valid = 1'b1; tx_len = 16'(len); tx_flags = fl;
      @(negedge clk); tx_valid = 1'b0;
   endtask

   task automatic clear_all();
      @(negedge clk); clr_stats = 1'b1;
      @(negedge clk); clr_stats = 1'b0;
   endtask

   task automatic t_reset();
      check("R12 rd_data reset", rd_data, 0);
      rd_chk("R1 rx octets", 0, 0);
      rd_chk("R1 tx multicast", TX + 4, 0);
      rd_chk("R1 rx frames hi", 3, 0);
   endtask

   task automatic t_totals();
      rx_ev(100, 8'h00); rx_ev(1500, 8'h00); rx_ev(64, 8'h00);
      rd_chk("R2 rx octets lo", 0, 1664);
      rd_chk("R2 rx octets hi", 1, 0);
      rd_chk("R3 rx frames lo", 2, 3);
      rd_chk("R8 rx octets cleared", 0, 0);
      rd_chk("R6 rx bin0", 12, 1);
      rd_chk("R6 rx bin1", 13, 1);
      rd_chk("R6 rx bin5", 17, 1);
      rd_chk("R6 rx bin2 empty", 14, 0);
   endtask

   task automatic t_flags();
      clear_all();
      tx_ev(200, 4'hF);
      rd_chk("R11 rx multicast untouched", 4, 0);
      rd_chk("R11 rx frames untouched", 2, 0);
      for (int b = 0; b < 4; b++) rd_chk("R5 tx flag counter", TX + 4 + b, 1);
      rd_chk("R6 tx bin2", TX + 10, 1);
      rd_chk("R3 tx frames", TX + 2, 1);
      rx_ev(40, 8'hFF);
      for (int b = 0; b < 8; b++) rd_chk("R4 rx flag counter", 4 + b, 1);
      for (int k = 0; k < 7; k++) rd_chk("R7 short frame no bin", 12 + k, 0);
      rd_chk("R11 tx frames untouched", TX + 2, 0);
      rx_ev(300, 8'h04);
      rd_chk("R4 pause only", 6, 1);
      rd_chk("R4 multicast not set", 4, 0);
   endtask

   task automatic t_bins();
      int lens[13] = '{63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519};
      int exp[7] = '{1, 2, 2, 2, 2, 2, 1};
      clear_all();
      foreach (lens[i]) tx_ev(lens[i], 4'h0);
      for (int k = 0; k < 7; k++) rd_chk("R6 tx bin boundary", TX + 8 + k, 32'(exp[k]));
      rd_chk("R3 tx frames incl. short", TX + 2, 13);
   endtask

   task automatic t_same_cycle();
      clear_all();
      rx_ev(80, 8'h01); rx_ev(80, 8'h01); rx_ev(80, 8'h01);
      @(negedge clk);
      rx_valid = 1'b1; rx_len = 16'd80; rx_flags = 8'h01; rd_en = 1'b1; rd_addr = 7'd4;
      @(negedge clk);
      rx_valid = 1'b0; rd_en = 1'b0;
      check("R8 read returns prior value", rd_data, 3);
      rd_chk("R8 event counted after clear", 4, 1);
   endtask

   task automatic t_wide_and_sat();
      clear_all();
      @(negedge clk); tx_valid = 1'b1; tx_len = 16'hFFFF; tx_flags = 4'h0;
      repeat (65540) @(negedge clk);
      tx_valid = 1'b0;
      rd_chk("R2 tx octets lo", TX + 0, 196604);
      rd_chk("R2 tx octets hi", TX + 1, 1);
      rd_chk("R2 tx octets hi held", TX + 1, 1);
      rd_chk("R3 tx frames lo", TX + 2, 65540);
      rd_chk("R3 tx frames hi", TX + 3, 0);
      rd_chk("R9 tx bin6 saturated", TX + 14, 63);
      clear_all();
      rd_chk("R10 shadow cleared", TX + 1, 0);
      rx_ev(700, 8'hFF);
      clear_all();
      rd_chk("R10 rx flag cleared", 4, 0);
      rd_chk("R10 rx bin cleared", 16, 0);
   endtask

   task automatic t_unmapped();
      rd_chk("R12 unmapped rx", 30, 0);
      rd_chk("R12 unmapped tx", TX + 20, 0);
      rx_ev(90, 8'h02);
      @(negedge clk); @(negedge clk);
      check("R12 rd_data holds", rd_data, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_totals();
      t_flags();
      t_bins();
      t_same_cycle();
      t_wide_and_sat();
      t_unmapped();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule